// File: doc/BRIEF.md
# Inter-core mailbox register file

This block holds a bank of 32-bit mailboxes that processor cores use to signal one another. Each core owns a group of mailboxes, and a mailbox's index is its core number times the group size plus its position within the group. The defaults give four cores with four mailboxes each, sixteen in all. Any core may post bits into any mailbox, and the owning core acknowledges them by clearing them.

The block sits on a single 32-bit register port with two address windows. A write to the set window ORs the data into the addressed mailbox. A write to the clear window clears the bits that are 1 in the data. The clear window is the only view through which a mailbox can be read.

For every mailbox the block drives a pending flag that is high while the mailbox holds any set bit. The interrupt router uses mailbox j of a core as that core's local source j+4. Enabling and routing of those sources are done in the router, not in this block.

Top module: `mbox_regfile`

## Requirements
- R1: After reset every mailbox reads as zero, all bits of `mbox_pending` are low and `rsp_valid` is low.
- R2: A valid write at byte address 0x80 + 4×index ORs `req_wdata` into that mailbox. Bits that were already set stay set.
- R3: A valid write at byte address 0xC0 + 4×index clears each mailbox bit whose data bit is 1 and leaves every other bit unchanged.
- R4: A read request at 0xC0 + 4×index is answered one cycle later. In that cycle `rsp_valid` is high and `rsp_rdata` holds the mailbox value. Every read request, valid or not, gets exactly one response.
- R5: A read in the set window (0x80 to 0xBF) returns zero and leaves the mailbox unchanged.
- R6: `mbox_pending[index]` is high exactly when the mailbox is non-zero. It changes on the clock edge that accepts the write. A set followed by a clear of the same bits leaves the flag low.
- R7: An access is valid only when `req_be` is 4'b1111, `req_addr[1:0]` is 0 and the address lies in 0x80 to 0xFF. Any other write changes nothing, and any other read returns zero.
- R8: Mailbox index equals core×4 + mailbox number, and bit `index` of `mbox_pending` belongs to that mailbox. A write changes only the mailbox it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_be | input | 4 | Byte enables; only all-ones is a valid access |
| req_wdata | input | 32 | Write data (set mask or clear mask) |
| rsp_valid | output | 1 | Read response strobe, one cycle after the read request |
| rsp_rdata | output | 32 | Read response data |
| mbox_pending | output | 16 | Per-mailbox non-zero flag |

## Verification
The bench builds the block with its default parameters: four cores, four mailboxes per core and 32-bit data. With these values both windows span the whole upper half of the 8-bit address space, so the first and last slot of each window, the edge at 0x80, out-of-window addresses, unaligned addresses and partial byte enables can all be exercised. Every one of the sixteen mailboxes is written with a distinct one-hot pattern, which shows that index mapping and flag position agree across all cores.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_MBOX = 16,
  parameter int SET_BASE = 'h80,
  parameter int BE_W     = 4,
  localparam int IDX_W   = $clog2(NUM_MBOX),
  localparam int CLR_BASE = SET_BASE + NUM_MBOX * 4,
  localparam int WIN_END  = CLR_BASE + NUM_MBOX * 4
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);
  int  addr_i;
  logic acc_ok;

  always_comb begin
    addr_i = int'(req_addr);
    acc_ok = req_valid && (&req_be) && (req_addr[1:0] == 2'b00);
    win    = WIN_NONE;
    idx    = '0;
    if (acc_ok && addr_i >= SET_BASE && addr_i < CLR_BASE) begin
      win = WIN_SET;
      idx = IDX_W'((addr_i - SET_BASE) >> 2);
    end else if (acc_ok && addr_i >= CLR_BASE && addr_i < WIN_END) begin
      win = WIN_CLR;
      idx = IDX_W'((addr_i - CLR_BASE) >> 2);
    end
  end
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              nonzero
);
  logic [DATA_W-1:0] val_q, val_d;
  logic              upd_en;

  always_comb begin
    upd_en = set_en | clr_en;
    val_d  = val_q;
    if (set_en)      val_d = val_q | wdata;
    else if (clr_en) val_d = val_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (upd_en) val_q <= val_d;
  end

  assign value   = val_q;
  assign nonzero = |val_q;

  AST_SET_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((val_q & $past(wdata)) == $past(wdata))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((val_q & $past(val_q)) == $past(val_q))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((val_q & $past(wdata)) == '0)); // R3
  AST_CLR_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((val_q & ~$past(wdata)) == ($past(val_q) & ~$past(wdata)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(val_q)); // R7
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R8
endmodule

// File: rtl/mbox_rsp.sv
module mbox_rsp #(
  parameter int DATA_W   = 32,
  parameter int NUM_MBOX = 16,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic                       rd_clr_hit,
  input  logic                       rd_set_hit,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_MBOX*DATA_W-1:0] mbox_flat,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = '0;
    if (rd_clr_hit) data_d = mbox_flat[rd_idx*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= rd_req;
      if (rd_req) data_q <= data_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = data_q;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R4
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R4
  AST_SETWIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_set_hit |=> (rsp_rdata == '0)); // R5
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int MBOX_PER_CORE = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int SET_BASE      = 'h80,
  localparam int NUM_MBOX     = NUM_CORES * MBOX_PER_CORE,
  localparam int IDX_W        = $clog2(NUM_MBOX),
  localparam int BE_W         = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BE_W-1:0]     req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [NUM_MBOX-1:0] mbox_pending
);
  logic                       rst_n;
  win_e                       win;
  logic [IDX_W-1:0]           idx;
  logic [NUM_MBOX*DATA_W-1:0] mbox_flat;
  logic                       wr_set, wr_clr, rd_req;

  mbox_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  mbox_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_MBOX (NUM_MBOX),
    .SET_BASE (SET_BASE),
    .BE_W     (BE_W)
  ) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .win       (win),
    .idx       (idx)
  );

  always_comb begin
    wr_set = req_write && (win == WIN_SET);
    wr_clr = req_write && (win == WIN_CLR);
    rd_req = req_valid && !req_write;
  end

  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_cell
    logic set_g, clr_g;
    assign set_g = wr_set && (idx == IDX_W'(g));
    assign clr_g = wr_clr && (idx == IDX_W'(g));
    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_g),
      .clr_en  (clr_g),
      .wdata   (req_wdata),
      .value   (mbox_flat[g*DATA_W +: DATA_W]),
      .nonzero (mbox_pending[g])
    );
  end

  mbox_rsp #(
    .DATA_W   (DATA_W),
    .NUM_MBOX (NUM_MBOX)
  ) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_clr_hit (rd_req && (win == WIN_CLR)),
    .rd_set_hit (rd_req && (win == WIN_SET)),
    .rd_idx     (idx),
    .mbox_flat  (mbox_flat),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  AST_FLAG_FALLS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((mbox_pending & $past(mbox_pending)) == $past(mbox_pending))); // R6
  AST_FLAG_RISES_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set |=> ((mbox_pending & ~$past(mbox_pending)) == '0)); // R6
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(mbox_pending ^ $past(mbox_pending))); // R8
endmodule

// File: tb/mbox_regfile_bench.sv
module mbox_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 16;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] mbox_pending;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mon_on = 0;

  logic [31:0] mdl [NMB];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_regfile u_mbox_regfile (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_be       (req_be),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .mbox_pending (mbox_pending)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < NMB; i++) p[i] = (mdl[i] != 0);
    return p;
  endfunction

  // Driver: one bus beat, returns at the negedge after the accepting edge.
  task automatic bus(bit wr, logic [7:0] addr, logic [31:0] data,
                     logic [3:0] be, logic [31:0] rd_exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    req_wdata = data; req_be = be;
    if (!wr) begin
      exp_q.push_back(rd_exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic mset(int i, logic [31:0] d);
    mdl[i] = mdl[i] | d;
    bus(1, 8'(8'h80 + 4*i), d, 4'hF, '0, "R2");
  endtask

  task automatic mclr(int i, logic [31:0] d);
    mdl[i] = mdl[i] & ~d;
    bus(1, 8'(8'hC0 + 4*i), d, 4'hF, '0, "R3");
  endtask

  task automatic mread(int i, string tag);
    bus(0, 8'(8'hC0 + 4*i), '0, 4'hF, mdl[i], tag);
  endtask

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (mon_on && rsp_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        check32(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    for (int i = 0; i < NMB; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    check32("R1 pending", 32'(mbox_pending), 32'h0);
    check32("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    mread(0, "R1 read mbox0");
    mread(15, "R1 read mbox15");

    // R2 set ORs in
    mset(5, 32'hA5A5_0000);
    check32("R6 pending after set", 32'(mbox_pending), 32'(exp_pend()));
    mread(5, "R4 read after set");
    mset(5, 32'h0000_00FF);
    mread(5, "R2 OR keeps old bits");

    // R3 clear selected bits
    mclr(5, 32'hA000_000F);
    mread(5, "R3 partial clear");
    check32("R6 pending partial clear", 32'(mbox_pending), 32'(exp_pend()));

    // R6 set then clear same bits
    mset(9, 32'h0000_0010);
    mclr(9, 32'h0000_0010);
    check32("R6 set then clear flag low", 32'(mbox_pending[9]), 32'h0);

    // R5 read set window
    bus(0, 8'h80 + 8'd20, '0, 4'hF, 32'h0, "R5 set window read zero");
    mread(5, "R5 mailbox unchanged");

    // R7 ignored accesses
    bus(1, 8'hC4 + 8'd16, 32'hFFFF_FFFF, 4'h7, '0, "R7");
    bus(1, 8'h81, 32'hFFFF_FFFF, 4'hF, '0, "R7");
    bus(1, 8'h40, 32'hFFFF_FFFF, 4'hF, '0, "R7");
    bus(1, 8'h7C, 32'hFFFF_FFFF, 4'hF, '0, "R7");
    check32("R7 pending unchanged", 32'(mbox_pending), 32'(exp_pend()));
    mread(5, "R7 mailbox5 unchanged");
    mread(0, "R7 mailbox0 unchanged");
    bus(0, 8'h40, '0, 4'hF, 32'h0, "R7 out of window read zero");
    bus(0, 8'hD4, '0, 4'h3, 32'h0, "R7 partial byte read zero");
    bus(0, 8'hD6, '0, 4'hF, 32'h0, "R7 unaligned read zero");

    // R8 mapping across all cores
    mclr(5, 32'hFFFF_FFFF);
    for (int c = 0; c < 4; c++) begin
      for (int j = 0; j < 4; j++) begin
        mset(c*4 + j, 32'h1 << (c*4 + j));
        check32("R8 pending bit position", 32'(mbox_pending), 32'(exp_pend()));
      end
    end
    for (int i = 0; i < NMB; i++) mread(i, "R8 read per mailbox");

    // R3 clear everything
    for (int i = 0; i < NMB; i++) mclr(i, 32'hFFFF_FFFF);
    check32("R3 all cleared pending", 32'(mbox_pending), 32'h0);
    mread(15, "R3 last mailbox zero");

    @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule